// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block divides a fast clock by an average ratio of N + F/M, where N is an integer and F/M is a proper fraction with both F and M held as 20-bit unsigned values. Each divide period is a whole number of input clocks, either N or N + 1. A first-order sigma-delta modulator with an arbitrary (not power-of-two) modulus M picks between the two once per output period, so that the long-run mean equals the programmed ratio. A one-bit pseudorandom dither from a 23-bit maximal-length shift register is fed into the modulator to break up the repeating pattern it would otherwise settle into. Only the difference between successive dither bits is injected, so the dither adds no bias to the mean.

Software or a neighbouring block presents a new N, F and M with a one-cycle load strobe. A legal setting is held in a pending register and becomes active at the next period boundary. An illegal setting raises an error flag and is dropped, and the last legal setting stays active. The divided output is a one-clock pulse on the final input clock of each period. The divide value for the current period is reported alongside it.

Top module: `frac_fb_divider`

## Requirements
- R1: Each output period lasts exactly `divValue` input clocks. `divPulse` is high for one clock only, on the last clock of the period.
- R2: During any period, `divValue` is either the active N or N + 1.
- R3: For an active setting with F > 0 running K periods from its activation, the count U of periods at N + 1 satisfies K·F − M ≤ U·M ≤ K·F + 1.
- R4: While the active F is zero, every period is exactly N clocks long, with no N + 1 periods.
- R5: After reset the active setting is N = `DEF_N`, F = 0, M = 1. `divValue` shows `DEF_N` and `cfgError` is 0.
- R6: `divValue` changes only between periods, never inside one. A load that is accepted while a period is running takes effect from the first period that starts after the load edge. When two loads arrive before a boundary, the later one wins.
- R7: A load is rejected when M = 0, when F ≥ M, or when N < 2. A rejected load sets `cfgError` one clock after the load strobe and leaves the active setting unchanged. A later legal load clears `cfgError`.
- R8: With dither active and F/M = 1/2, the sequence of divide values is not a strict alternation. Two equal consecutive values appear within 100 periods.
- R9: An accepted setting with the smallest step (M = 2^20 − 1, F = M − 1) keeps the average within the R3 bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed input clock being divided |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | One-cycle strobe that presents intDiv, fracNum and fracMod |
| intDiv | input | NW | Integer part N of the ratio |
| fracNum | input | FW | Fraction numerator F |
| fracMod | input | FW | Fraction modulus M |
| divPulse | output | 1 | One-clock pulse on the last clock of each period |
| divValue | output | NW+1 | Divide value in force for the current period |
| cfgError | output | 1 | Last load was rejected |

## Verification
The ratio is tried as a pure integer, as a coarse half, as an odd fraction (3/7), as a near-unity fraction at the finest resolution, and with the largest integer part. These show apart three things: integer-only behaviour, the modulator's average accuracy, and the handling of wide counter values. A run at 1/2 separates a dithered modulator from a plain accumulator, which would strictly alternate. Rejected loads of each illegal kind are interleaved with legal ones, and back-to-back loads test the boundary rule. A bench-side period model checks every clock for pulse placement and for the value held across each period.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  localparam int unsigned LFSR_W    = 23;
  localparam int unsigned LFSR_TAP  = 18;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 23'h3A5C91;

  typedef struct packed {
    logic reload;
    logic stepUp;
  } divStrobe_t;

endpackage

// File: rtl/frac_div_lfsr.sv
module frac_div_lfsr #(
  parameter int unsigned W    = frac_div_pkg::LFSR_W,
  parameter int unsigned TAP  = frac_div_pkg::LFSR_TAP,
  parameter logic [W-1:0] SEED = frac_div_pkg::LFSR_SEED
) (
  input  logic clk,
  input  logic rstN,
  input  logic advance,
  output logic ditherBit
);

  logic [W-1:0] state;
  logic         feedback;

  assign feedback  = state[W-1] ^ state[TAP-1];
  assign ditherBit = state[W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEED;
    end else if (advance) begin
      state <= {state[W-2:0], feedback};
    end
  end

  // R8
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
  import frac_div_pkg::*;
#(
  parameter int unsigned NW    = 8,
  parameter int unsigned FW    = 20,
  parameter int unsigned DEF_N = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgLoad,
  input  logic [NW-1:0] intDiv,
  input  logic [FW-1:0] fracNum,
  input  logic [FW-1:0] fracMod,
  input  logic          lastCycle,
  output divStrobe_t    strobe,
  output logic [NW-1:0] baseDiv,
  output logic          cfgError
);

  localparam int unsigned SW = FW + 2;
  localparam logic [NW-1:0] RST_N = NW'(DEF_N);

  logic [NW-1:0] actN, pendN, useN;
  logic [FW-1:0] actF, pendF, useF;
  logic [FW-1:0] actM, pendM, useM;
  logic          pendValid;
  logic [FW-1:0] acc, accIn;
  logic          dPrev;
  logic          ditherBit;
  logic          ditherOn;
  logic          loadBad;
  logic [SW-1:0] sumPre, sumW, accNextW;
  logic          carry;

  assign loadBad = (fracMod == '0) || (fracNum >= fracMod) || (intDiv < NW'(2));

  assign useN  = pendValid ? pendN : actN;
  assign useF  = pendValid ? pendF : actF;
  assign useM  = pendValid ? pendM : actM;
  assign accIn = pendValid ? '0 : acc;

  assign ditherOn = (useF != '0);

  always_comb begin
    sumPre = {2'b00, accIn} + {2'b00, useF} + SW'(ditherOn & ditherBit);
    sumW   = sumPre - SW'(ditherOn & dPrev);
    carry  = (sumW >= {2'b00, useM});
    accNextW = carry ? (sumW - {2'b00, useM}) : sumW;
  end

  frac_div_lfsr u_lfsr (
    .clk       (clk),
    .rstN      (rstN),
    .advance   (lastCycle & ditherOn),
    .ditherBit (ditherBit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actN      <= RST_N;
      actF      <= '0;
      actM      <= FW'(1);
      pendN     <= RST_N;
      pendF     <= '0;
      pendM     <= FW'(1);
      pendValid <= 1'b0;
      acc       <= '0;
      dPrev     <= 1'b0;
      cfgError  <= 1'b0;
    end else begin
      if (lastCycle) begin
        acc <= accNextW[FW-1:0];
        if (ditherOn) dPrev <= ditherBit;
        if (pendValid) begin
          actN      <= pendN;
          actF      <= pendF;
          actM      <= pendM;
          pendValid <= 1'b0;
        end
      end
      if (cfgLoad) begin
        cfgError <= loadBad;
        if (!loadBad) begin
          pendN     <= intDiv;
          pendF     <= fracNum;
          pendM     <= fracMod;
          pendValid <= 1'b1;
        end
      end
    end
  end

  assign strobe.reload = lastCycle;
  assign strobe.stepUp = carry;
  assign baseDiv       = useN;

  // R3
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc < actM);

  // R4
  int_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastCycle && useF == '0) |-> !strobe.stepUp);

  // R7
  legal_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (actM != '0) && (actF < actM) && (actN >= NW'(2)));

endmodule

// File: rtl/frac_div_dp.sv
module frac_div_dp
  import frac_div_pkg::*;
#(
  parameter int unsigned NW    = 8,
  parameter int unsigned DEF_N = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  divStrobe_t    strobe,
  input  logic [NW-1:0] baseDiv,
  output logic          lastCycle,
  output logic [NW:0]   divValue
);

  localparam logic [NW:0] RST_DIV = (NW+1)'(DEF_N);

  logic [NW:0] cnt;
  logic [NW:0] loadVal;

  assign loadVal   = {1'b0, baseDiv} + (NW+1)'(strobe.stepUp);
  assign lastCycle = (cnt == (NW+1)'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= RST_DIV;
      divValue <= RST_DIV;
    end else if (strobe.reload) begin
      cnt      <= loadVal;
      divValue <= loadVal;
    end else begin
      cnt      <= cnt - (NW+1)'(1);
    end
  end

  // R1
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastCycle |=> !lastCycle);

  // R1
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt != '0);

  // R6
  div_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lastCycle |=> $stable(divValue));

  // R7
  div_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    divValue >= (NW+1)'(2));

endmodule

// File: rtl/frac_fb_divider.sv
module frac_fb_divider
  import frac_div_pkg::*;
#(
  parameter int unsigned NW    = 8,
  parameter int unsigned FW    = 20,
  parameter int unsigned DEF_N = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgLoad,
  input  logic [NW-1:0] intDiv,
  input  logic [FW-1:0] fracNum,
  input  logic [FW-1:0] fracMod,
  output logic          divPulse,
  output logic [NW:0]   divValue,
  output logic          cfgError
);

  divStrobe_t    strobe;
  logic [NW-1:0] baseDiv;
  logic          lastCycle;

  frac_div_ctrl #(.NW(NW), .FW(FW), .DEF_N(DEF_N)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgLoad   (cfgLoad),
    .intDiv    (intDiv),
    .fracNum   (fracNum),
    .fracMod   (fracMod),
    .lastCycle (lastCycle),
    .strobe    (strobe),
    .baseDiv   (baseDiv),
    .cfgError  (cfgError)
  );

  frac_div_dp #(.NW(NW), .DEF_N(DEF_N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .baseDiv   (baseDiv),
    .lastCycle (lastCycle),
    .divValue  (divValue)
  );

  assign divPulse = lastCycle;

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (divValue == {1'b0, $past(baseDiv)}) ||
                      (divValue == {1'b0, $past(baseDiv)} + (NW+1)'(1)));

endmodule

// File: tb/frac_fb_divider_test.sv
module frac_fb_divider_test;

  localparam int NW = 8;
  localparam int FW = 20;
  localparam int DEF_N = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgLoad = 1'b0;
  logic [NW-1:0] intDiv = '0;
  logic [FW-1:0] fracNum = '0;
  logic [FW-1:0] fracMod = '0;
  logic          divPulse;
  logic [NW:0]   divValue;
  logic          cfgError;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  int expN = DEF_N, expF = 0, expM = 1;
  int pendN, pendF, pendM;
  bit pendOn = 0;
  bit armed = 0;
  int armN, armF, armM;
  bit armBad;
  int pos = 0, periodLen = 0, prevVal = 0;
  int epPeriods = 0, epUps = 0, repeats = 0;
  int pulsesSeen = 0;

  always #10 clk = ~clk;

  frac_fb_divider #(.NW(NW), .FW(FW), .DEF_N(DEF_N)) uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .intDiv(intDiv),
    .fracNum(fracNum), .fracMod(fracMod), .divPulse(divPulse),
    .divValue(divValue), .cfgError(cfgError)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic closeEpoch();
    longint kf, um;
    if (expF != 0 && epPeriods >= 10) begin
      kf = longint'(epPeriods) * expF;
      um = longint'(epUps) * expM;
      // R3 (and R9 for the finest step): average ratio bound
      check(um >= kf - expM && um <= kf + 1, "R3/R9 average", um, kf);
      if (2 * expF == expM && epPeriods >= 40)
        check(repeats > 0, "R8 dither breaks alternation", repeats, 1);
    end
    epPeriods = 0; epUps = 0; repeats = 0;
  endtask

  task automatic observe();
    if (armed) begin
      armed = 0;
      check(cfgError == armBad, "R7 error flag", cfgError, armBad);
      if (!armBad) begin
        pendOn = 1; pendN = armN; pendF = armF; pendM = armM;
      end
    end
    if (pos == 0) begin
      periodLen = divValue;
      check(divValue == expN || divValue == expN + 1, "R2 value range", divValue, expN);
      if (expF == 0) check(divValue == expN, "R4 integer only", divValue, expN);
      if (epPeriods > 0 && divValue == prevVal) repeats++;
      prevVal = divValue;
      epPeriods++;
      if (divValue == expN + 1) epUps++;
    end else begin
      check(divValue == periodLen, "R6 value held in period", divValue, periodLen);
    end
    check(divPulse == (pos == periodLen - 1), "R1 pulse position", divPulse, pos == periodLen - 1);
    if (divPulse) begin
      pos = 0;
      pulsesSeen++;
      if (pendOn) begin
        closeEpoch();
        expN = pendN; expF = pendF; expM = pendM;
        pendOn = 0;
      end
    end else begin
      pos++;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    observe();
  endtask

  task automatic runPeriods(input int k);
    int target;
    target = pulsesSeen + k;
    while (pulsesSeen < target) tick();
  endtask

  task automatic doLoad(input int n, input int f, input int m);
    intDiv = NW'(n); fracNum = FW'(f); fracMod = FW'(m);
    cfgLoad = 1'b1;
    armN = n; armF = f; armM = m;
    armBad = (m == 0) || (f >= m) || (n < 2);
    armed = 1;
    tick();
    cfgLoad = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    check(divValue == DEF_N, "R5 reset divide value", divValue, DEF_N);
    check(cfgError == 0, "R5 reset error flag", cfgError, 0);
    rstN = 1'b1;
    observe();
    runPeriods(10);                      // R4 default integer setting
    doLoad(6, 0, 5);  runPeriods(20);    // R4 with nonunit modulus
    doLoad(4, 1, 2);  runPeriods(100);   // R8, R3 half fraction
    doLoad(4, 3, 0);  runPeriods(10);    // R7 M zero
    doLoad(4, 5, 5);  runPeriods(10);    // R7 F equal M
    doLoad(1, 1, 3);  runPeriods(10);    // R7 N below two
    doLoad(5, 3, 7);                     // R7 clears flag
    runPeriods(200);                     // R3 odd fraction
    doLoad(3, 1048574, 1048575);         // R9 finest step
    runPeriods(300);
    doLoad(255, 1, 3); runPeriods(12);   // R2 widest value
    doLoad(7, 0, 1);                     // R6 two loads, later wins
    doLoad(9, 0, 1);
    runPeriods(6);
    check(expN == 9, "R6 later load wins", divValue, 9);
    check(divValue == 9, "R6 active value", divValue, 9);
    closeEpoch();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule